// File: doc/BRIEF.md
# USB controller control/status register block

This block is a bank of 32-bit word registers that sits beside a USB host controller. It holds the static configuration that the controller samples: bus filter bypass, port strap bits, frame-length adjust, endianness select, coherency enable and bus-master enable. It also holds a small interrupt unit that collects two error sources into one level interrupt.

Software reaches the registers through a single-cycle bus-slave port. A request is presented with address, write enable and write data. The read data and the error response are valid combinationally in the same cycle. Writes take effect at the next rising clock edge.

The interrupt mask cannot be written directly. Software clears mask bits through the enable register and sets them through the disable register. Status bits are set by hardware event pulses and cleared by writing a one.

Top module: `usb_ctl_csr`

## Requirements
- R1: After reset the frame-length adjust output is 0x20, bus-master enable is 1, the interrupt mask reads 0x3, and every other configuration output, the status and the interrupt output are 0.
- R2: The configuration registers are read/write on their defined bits only, and every reserved bit reads 0. The defined bits are: filter bypass [3:0] at 0x30, port straps [4:0] at 0x34, frame-length adjust [5:0] at 0x38, endian select [0] at 0x40, coherency [0] at 0x44, bus-master enable [0] at 0x48 and slave-error enable [0] at 0x60.
- R3: The mask register at 0x68 is read-only, and a write to it leaves the mask unchanged.
- R4: A write to 0x6C clears each mask bit whose write-data bit is 1. A write to 0x70 sets each such mask bit. Both addresses read 0.
- R5: The status register at 0x64 (bit 0 address-decode error, bit 1 host system error) clears a bit when a 1 is written to it; a written 0 leaves the bit unchanged.
- R6: A high bit on evt_i sets the matching status bit at the next clock edge. If an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R7: irq_o is high exactly when some status bit is 1 and its mask bit is 0.
- R8: With slave-error enable set, an access to an unmapped address raises err_o, returns read data 0 and sets status bit 0. With it clear, the access completes with no error, read data 0 and no status change.
- R9: An address whose two low bits are not zero counts as unmapped.
- R10: The spare register at 0x78 is mapped: it reads 0, ignores writes and never returns an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high |
| err_o | output | 1 | Error response for the current access |
| evt_i | input | 2 | Error event pulses: bit 0 address decode, bit 1 host system |
| filt_bypass_o | output | 4 | Bus filter bypass |
| port_cfg_o | output | 5 | Port strap bits |
| fladj_o | output | 6 | Frame-length adjust |
| big_endian_o | output | 1 | Endianness select |
| coherent_o | output | 1 | Coherency enable |
| bus_master_en_o | output | 1 | Bus-master enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default ADDR_W of 8. That width places the whole register map and the holes between registers within reach, and it also places addresses above 0x78 that decode to nothing. Misaligned addresses inside a mapped word can be reached as well. These cover the decode-error path in both settings of the slave-error enable. The bench also exercises both interrupt sources against every mask state.

// File: rtl/usb_ctl_csr_pkg.sv
`timescale 1ns/1ps
package usb_ctl_csr_pkg;
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned SRC_DEC = 0;
  localparam int unsigned SRC_HSE = 1;

  localparam logic [7:0] OFF_FILT   = 8'h30;
  localparam logic [7:0] OFF_PORT   = 8'h34;
  localparam logic [7:0] OFF_FLADJ  = 8'h38;
  localparam logic [7:0] OFF_ENDIAN = 8'h40;
  localparam logic [7:0] OFF_COH    = 8'h44;
  localparam logic [7:0] OFF_BME    = 8'h48;
  localparam logic [7:0] OFF_RCTL   = 8'h60;
  localparam logic [7:0] OFF_IST    = 8'h64;
  localparam logic [7:0] OFF_IMSK   = 8'h68;
  localparam logic [7:0] OFF_IEN    = 8'h6C;
  localparam logic [7:0] OFF_IDIS   = 8'h70;
  localparam logic [7:0] OFF_SPARE  = 8'h78;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FILT, SEL_PORT, SEL_FLADJ, SEL_ENDIAN, SEL_COH, SEL_BME,
    SEL_RCTL, SEL_IST, SEL_IMSK, SEL_IEN, SEL_IDIS, SEL_SPARE
  } csr_sel_e;
endpackage

// File: rtl/usb_ctl_csr_dec.sv
`timescale 1ns/1ps
module usb_ctl_csr_dec
  import usb_ctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_FILT))   sel_o = SEL_FILT;
    else if (addr_i == ADDR_W'(OFF_PORT))   sel_o = SEL_PORT;
    else if (addr_i == ADDR_W'(OFF_FLADJ))  sel_o = SEL_FLADJ;
    else if (addr_i == ADDR_W'(OFF_ENDIAN)) sel_o = SEL_ENDIAN;
    else if (addr_i == ADDR_W'(OFF_COH))    sel_o = SEL_COH;
    else if (addr_i == ADDR_W'(OFF_BME))    sel_o = SEL_BME;
    else if (addr_i == ADDR_W'(OFF_RCTL))   sel_o = SEL_RCTL;
    else if (addr_i == ADDR_W'(OFF_IST))    sel_o = SEL_IST;
    else if (addr_i == ADDR_W'(OFF_IMSK))   sel_o = SEL_IMSK;
    else if (addr_i == ADDR_W'(OFF_IEN))    sel_o = SEL_IEN;
    else if (addr_i == ADDR_W'(OFF_IDIS))   sel_o = SEL_IDIS;
    else if (addr_i == ADDR_W'(OFF_SPARE))  sel_o = SEL_SPARE;
  end
endmodule

// File: rtl/usb_ctl_csr_field.sv
`timescale 1ns/1ps
module usb_ctl_csr_field #(
  parameter int unsigned W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/usb_ctl_csr_irq.sv
`timescale 1ns/1ps
module usb_ctl_csr_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         en_wr_i,
  input  logic         dis_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q, clr;

  assign clr = clr_wr_i ? wdata_i : '0;

  // event has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '1;
    else if (en_wr_i)  mask_q <= mask_q & ~wdata_i;
    else if (dis_wr_i) mask_q <= mask_q | wdata_i;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  a_r3_mask_only_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q != $past(mask_q)) |-> $past(en_wr_i || dis_wr_i));
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((status_q & $past(wdata_i & ~set_i)) == '0));
  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/usb_ctl_csr.sv
`timescale 1ns/1ps
module usb_ctl_csr
  import usb_ctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [5:0]  FLADJ_RST = 6'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic [N_SRC-1:0]  evt_i,
  output logic [3:0]        filt_bypass_o,
  output logic [4:0]        port_cfg_o,
  output logic [5:0]        fladj_o,
  output logic              big_endian_o,
  output logic              coherent_o,
  output logic              bus_master_en_o,
  output logic              irq_o
);
  csr_sel_e   sel;
  logic       wr, miss, slverr_q;
  logic [N_SRC-1:0] status, mask, set;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i[31:6];

  usb_ctl_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .sel_o(sel));

  assign wr   = req_i && we_i;
  assign miss = req_i && (sel == SEL_NONE);

  usb_ctl_csr_field #(.W(4), .RST(4'h0)) u_filt (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_FILT), .d_i(wdata_i[3:0]), .q_o(filt_bypass_o));
  usb_ctl_csr_field #(.W(5), .RST(5'h0)) u_port (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_PORT), .d_i(wdata_i[4:0]), .q_o(port_cfg_o));
  usb_ctl_csr_field #(.W(6), .RST(FLADJ_RST)) u_fladj (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_FLADJ), .d_i(wdata_i[5:0]), .q_o(fladj_o));
  usb_ctl_csr_field #(.W(1), .RST(1'b0)) u_endian (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_ENDIAN), .d_i(wdata_i[0]), .q_o(big_endian_o));
  usb_ctl_csr_field #(.W(1), .RST(1'b0)) u_coh (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_COH), .d_i(wdata_i[0]), .q_o(coherent_o));
  usb_ctl_csr_field #(.W(1), .RST(1'b1)) u_bme (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_BME), .d_i(wdata_i[0]), .q_o(bus_master_en_o));
  usb_ctl_csr_field #(.W(1), .RST(1'b0)) u_rctl (.clk_i, .rst_ni,
    .we_i(wr && sel == SEL_RCTL), .d_i(wdata_i[0]), .q_o(slverr_q));

  always_comb begin
    set = evt_i;
    if (miss && slverr_q) set[SRC_DEC] = 1'b1;
  end

  usb_ctl_csr_irq #(.N(N_SRC)) u_irq (
    .clk_i, .rst_ni,
    .set_i    (set),
    .clr_wr_i (wr && sel == SEL_IST),
    .en_wr_i  (wr && sel == SEL_IEN),
    .dis_wr_i (wr && sel == SEL_IDIS),
    .wdata_i  (wdata_i[N_SRC-1:0]),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i) begin
      unique case (sel)
        SEL_FILT:   rdata_o = 32'(filt_bypass_o);
        SEL_PORT:   rdata_o = 32'(port_cfg_o);
        SEL_FLADJ:  rdata_o = 32'(fladj_o);
        SEL_ENDIAN: rdata_o = 32'(big_endian_o);
        SEL_COH:    rdata_o = 32'(coherent_o);
        SEL_BME:    rdata_o = 32'(bus_master_en_o);
        SEL_RCTL:   rdata_o = 32'(slverr_q);
        SEL_IST:    rdata_o = 32'(status);
        SEL_IMSK:   rdata_o = 32'(mask);
        default:    rdata_o = '0;
      endcase
    end
  end

  assign err_o = miss && slverr_q;

  a_r8_err_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (req_i && slverr_q && rdata_o == '0));
  a_r9_misaligned_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && slverr_q && addr_i[1:0] != 2'b00) |-> err_o);
endmodule

// File: tb/usb_ctl_csr_bench.sv
`timescale 1ns/1ps
module usb_ctl_csr_bench;
  localparam int unsigned ADDR_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, irq, endian, coh, bme;
  logic [1:0] evt = '0;
  logic [3:0] filt;
  logic [4:0] port;
  logic [5:0] fladj;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_ctl_csr #(.ADDR_W(ADDR_W)) u_usb_ctl_csr (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .evt_i(evt),
    .filt_bypass_o(filt), .port_cfg_o(port), .fladj_o(fladj),
    .big_endian_o(endian), .coherent_o(coh), .bus_master_en_o(bme), .irq_o(irq));

  typedef struct {
    bit          is_rd;
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every bus response against the scoreboard queue
  always @(negedge clk) begin
    if (req && rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " err"}, 32'(err), 32'(e.err));
      if (e.is_rd) chk({e.tag, " rdata"}, rdata, e.data);
    end
  end

  task automatic op(bit w, logic [ADDR_W-1:0] a, logic [31:0] d,
                    logic [31:0] exp_d, logic exp_e, string tag);
    exp_t e;
    e.is_rd = !w; e.data = exp_d; e.err = exp_e; e.tag = tag;
    exp_q.push_back(e);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, string tag, logic exp_e = 1'b0);
    op(1'b1, a, d, '0, exp_e, tag);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp_d, string tag, logic exp_e = 1'b0);
    op(1'b0, a, '0, exp_d, exp_e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 fladj", 32'(fladj), 32'h20);
    chk("R1 bme", 32'(bme), 32'h1);
    chk("R1 others", {filt, port, endian, coh}, '0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(8'h38, 32'h20, "R1 fladj rd");
    rd(8'h48, 32'h1, "R1 bme rd");
    rd(8'h68, 32'h3, "R1 mask rd");
    rd(8'h64, 32'h0, "R1 status rd");

    // R2 config registers, reserved bits read zero
    wr(8'h30, 32'hFFFF_FFFF, "R2 filt wr");
    rd(8'h30, 32'hF, "R2 filt rd");
    chk("R2 filt out", 32'(filt), 32'hF);
    wr(8'h34, 32'hFFFF_FFFF, "R2 port wr");
    rd(8'h34, 32'h1F, "R2 port rd");
    chk("R2 port out", 32'(port), 32'h1F);
    wr(8'h38, 32'hFFFF_FF15, "R2 fladj wr");
    rd(8'h38, 32'h15, "R2 fladj rd");
    chk("R2 fladj out", 32'(fladj), 32'h15);
    wr(8'h40, 32'h3, "R2 endian wr");
    rd(8'h40, 32'h1, "R2 endian rd");
    wr(8'h44, 32'hFFFF_FFFF, "R2 coh wr");
    chk("R2 coh out", {endian, coh}, 32'h3);
    wr(8'h48, 32'hFFFF_FFFE, "R2 bme wr");
    rd(8'h48, 32'h0, "R2 bme rd");
    chk("R2 bme out", 32'(bme), 32'h0);

    // R3 mask is read-only
    wr(8'h68, 32'h0, "R3 mask wr");
    rd(8'h68, 32'h3, "R3 mask rd");

    // R6 event sets status; R7 masked -> no irq
    evt = 2'b10; @(posedge clk); #1 evt = 2'b00;
    rd(8'h64, 32'h2, "R6 evt sets hse");
    chk("R7 masked irq", 32'(irq), 32'h0);

    // R4 enable clears mask bit
    wr(8'h6C, 32'h2, "R4 en wr");
    rd(8'h68, 32'h1, "R4 mask after en");
    rd(8'h6C, 32'h0, "R4 en reads zero");
    rd(8'h70, 32'h0, "R4 dis reads zero");
    chk("R7 irq unmasked", 32'(irq), 32'h1);

    // R5 write-one-to-clear
    wr(8'h64, 32'h0, "R5 w0");
    rd(8'h64, 32'h2, "R5 w0 keeps");
    wr(8'h64, 32'h2, "R5 w1");
    rd(8'h64, 32'h0, "R5 w1 clears");
    chk("R7 irq after clear", 32'(irq), 32'h0);

    // R6 event wins over clear in same cycle
    evt = 2'b10;
    wr(8'h64, 32'h3, "R6 clr+evt");
    evt = 2'b00;
    rd(8'h64, 32'h2, "R6 event wins");
    wr(8'h64, 32'h3, "R6 cleanup");

    // R8 unmapped with slave error disabled
    rd(8'h10, 32'h0, "R8 miss no err", 1'b0);
    wr(8'h90, 32'hFFFF_FFFF, "R8 miss wr no err", 1'b0);
    rd(8'h64, 32'h0, "R8 no status");

    // R8 enabled
    wr(8'h60, 32'hFFFF_FFFF, "R8 rctl wr");
    rd(8'h60, 32'h1, "R8 rctl rd");
    rd(8'h10, 32'h0, "R8 miss err", 1'b1);
    rd(8'h64, 32'h1, "R8 dec status");
    chk("R7 dec masked", 32'(irq), 32'h0);
    wr(8'h6C, 32'h1, "R4 en dec");
    chk("R7 dec irq", 32'(irq), 32'h1);
    wr(8'h70, 32'h3, "R4 dis all");
    rd(8'h68, 32'h3, "R4 mask after dis");
    chk("R7 irq after dis", 32'(irq), 32'h0);

    // R9 misaligned is unmapped
    wr(8'h64, 32'h1, "R9 clr dec");
    rd(8'h31, 32'h0, "R9 misaligned err", 1'b1);
    rd(8'h64, 32'h1, "R9 dec status set");
    chk("R9 filt untouched", 32'(filt), 32'hF);

    // R10 spare register
    wr(8'h78, 32'hFFFF_FFFF, "R10 spare wr", 1'b0);
    rd(8'h78, 32'h0, "R10 spare rd", 1'b0);

    @(posedge clk); #1;
    chk("queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule